// File: doc/BRIEF.md
# Circular Buffer Index Updater

This block advances an index into a circular buffer by one modulo step. Its input is a packed control word: the low half holds the current index and the high half holds a signed step. A second input word supplies the largest legal index in its low bits. The block returns the control word with the index field replaced by the advanced index. The step field is copied into the result unchanged, so the same word can be fed back on the next access.

The two wraps behave differently. A positive step that carries the index past the maximum restarts it at zero. A negative step that takes the index below zero reloads it with the maximum. Neither wrap keeps the remainder of the step, so neither is a true modulo. The sum is formed two bits wider than the fields, so a carry out of the index field or a negative result is always seen. The output is registered by default. It carries a one-cycle valid strobe and holds its last value between updates.

Top module: `circ_index_step`

## Requirements
- R1: While reset is high and after it is released, with no valid input yet, `out_valid` is 0 and `out_word` is 0.
- R2: Bits 31:16 of `out_word` equal bits 31:16 of the `ctrl_word` that produced it.
- R3: When no wrap applies, the new index (bits 15:0 of `out_word`) is the current index (bits 15:0 of `ctrl_word`) plus the two's-complement step (bits 31:16), kept to 16 bits.
- R4: With a positive step, a full-precision sum greater than the maximum (bits 15:0 of `limit_word`) gives a new index of 0. This also holds when the sum exceeds 0xFFFF.
- R5: With a negative step, a sum below zero gives a new index equal to the maximum.
- R6: A zero step returns the current index unchanged, even when that index is above the maximum.
- R7: Bits 31:16 of `limit_word` have no effect on the result.
- R8: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_word` changes only in that cycle and otherwise holds its value.
- R9: A sum exactly equal to the maximum with a positive step, or exactly zero with a negative step, does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe for one update |
| ctrl_word | input | 32 | Packed control: index in 15:0, signed step in 31:16 |
| limit_word | input | 32 | Maximum index in 15:0; upper bits unused |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_word | output | 32 | Updated control word: new index in 15:0, step in 31:16 |

## Verification
The wrap test and the carry out of the 16-bit index field can happen in the same update. This occurs when a large positive step starts from an index near 0xFFFF and the maximum is 0xFFFF. An adder only 16 bits wide would alias that sum to a small index and miss the wrap. The bench provokes the case directly and judges it against a model in integer arithmetic, which must give 0 rather than the aliased value. The exact-boundary sums and a random stream, with idle cycles mixed in, are compared against the same model on every clock.

// File: rtl/cbi_pkg.sv
package cbi_pkg;
  typedef enum logic [1:0] {
    WRAP_NONE    = 2'd0,
    WRAP_TO_ZERO = 2'd1,
    WRAP_TO_MAX  = 2'd2
  } wrap_kind_e;
endpackage

// File: rtl/cbi_unpack.sv
module cbi_unpack #(
  parameter int IDX_W  = 16,
  parameter int STEP_W = 16,
  parameter int LIM_W  = 32,
  localparam int WORD_W = IDX_W + STEP_W
) (
  input  logic [WORD_W-1:0] ctrl_word,
  input  logic [LIM_W-1:0]  limit_word,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [STEP_W-1:0] step,
  output logic [IDX_W-1:0]  max_idx
);
  assign cur_idx = ctrl_word[IDX_W-1:0];
  assign step    = ctrl_word[WORD_W-1:IDX_W];
  assign max_idx = limit_word[IDX_W-1:0];

  generate
    if (LIM_W > IDX_W) begin : g_spare
      logic unused_limit_hi;
      assign unused_limit_hi = ^limit_word[LIM_W-1:IDX_W];
    end
  endgenerate
endmodule

// File: rtl/cbi_wrap.sv
module cbi_wrap
  import cbi_pkg::*;
#(
  parameter int IDX_W  = 16,
  parameter int STEP_W = 16,
  localparam int WIDE_W = ((IDX_W > STEP_W) ? IDX_W : STEP_W) + 2
) (
  input  logic [IDX_W-1:0]  cur_idx,
  input  logic [STEP_W-1:0] step,
  input  logic [IDX_W-1:0]  max_idx,
  output logic [IDX_W-1:0]  new_idx
);
  logic signed [WIDE_W-1:0] idx_wide;
  logic signed [WIDE_W-1:0] step_wide;
  logic signed [WIDE_W-1:0] max_wide;
  logic signed [WIDE_W-1:0] sum_wide;
  logic                     step_pos;
  logic                     step_neg;
  wrap_kind_e               kind;

  assign idx_wide  = $signed({{(WIDE_W-IDX_W){1'b0}}, cur_idx});
  assign max_wide  = $signed({{(WIDE_W-IDX_W){1'b0}}, max_idx});
  assign step_wide = $signed({{(WIDE_W-STEP_W){step[STEP_W-1]}}, step});
  assign sum_wide  = idx_wide + step_wide;

  assign step_neg = step[STEP_W-1];
  assign step_pos = !step[STEP_W-1] && (|step);

  always_comb begin
    if (step_pos && (sum_wide > max_wide))
      kind = WRAP_TO_ZERO;
    else if (step_neg && (sum_wide < 0))
      kind = WRAP_TO_MAX;
    else
      kind = WRAP_NONE;
  end

  always_comb begin
    case (kind)
      WRAP_TO_ZERO: new_idx = '0;
      WRAP_TO_MAX:  new_idx = max_idx;
      default:      new_idx = sum_wide[IDX_W-1:0];
    endcase
  end
endmodule

// File: rtl/cbi_out_reg.sv
module cbi_out_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         d_valid,
  input  logic [W-1:0] d_word,
  output logic         q_valid,
  output logic [W-1:0] q_word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_word  <= '0;
    end else begin
      q_valid <= d_valid;
      if (d_valid) q_word <= d_word;
    end
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    d_valid |=> q_valid);
  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !d_valid |=> !q_valid);
  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !d_valid |=> $stable(q_word));
endmodule

// File: rtl/circ_index_step.sv
module circ_index_step #(
  parameter int IDX_W   = 16,
  parameter int STEP_W  = 16,
  parameter int LIM_W   = 32,
  parameter bit OUT_REG = 1'b1,
  localparam int WORD_W = IDX_W + STEP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] ctrl_word,
  input  logic [LIM_W-1:0]  limit_word,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word
);
  logic [IDX_W-1:0]  cur_idx;
  logic [STEP_W-1:0] step;
  logic [IDX_W-1:0]  max_idx;
  logic [IDX_W-1:0]  new_idx;
  logic [WORD_W-1:0] next_word;

  cbi_unpack #(.IDX_W(IDX_W), .STEP_W(STEP_W), .LIM_W(LIM_W)) u_unpack (
    .ctrl_word (ctrl_word),
    .limit_word(limit_word),
    .cur_idx   (cur_idx),
    .step      (step),
    .max_idx   (max_idx)
  );

  cbi_wrap #(.IDX_W(IDX_W), .STEP_W(STEP_W)) u_wrap (
    .cur_idx(cur_idx),
    .step   (step),
    .max_idx(max_idx),
    .new_idx(new_idx)
  );

  assign next_word = {step, new_idx};

  generate
    if (OUT_REG) begin : g_reg
      cbi_out_reg #(.W(WORD_W)) u_out (
        .clk    (clk),
        .rst    (rst),
        .d_valid(in_valid),
        .d_word (next_word),
        .q_valid(out_valid),
        .q_word (out_word)
      );

      // R2
      step_pass_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_word[WORD_W-1:IDX_W] == $past(ctrl_word[WORD_W-1:IDX_W]));
      // R4
      pos_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ctrl_word[WORD_W-1] && |ctrl_word[WORD_W-1:IDX_W])
        |=> out_word[IDX_W-1:0] <= $past(limit_word[IDX_W-1:0]));
      // R5
      neg_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctrl_word[WORD_W-1] && ctrl_word[IDX_W-1:0] <= limit_word[IDX_W-1:0])
        |=> out_word[IDX_W-1:0] <= $past(limit_word[IDX_W-1:0]));
      // R6
      zero_step_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctrl_word[WORD_W-1:IDX_W] == '0)
        |=> out_word[IDX_W-1:0] == $past(ctrl_word[IDX_W-1:0]));
    end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst;
      assign out_valid = in_valid;
      assign out_word  = next_word;
    end
  endgenerate
endmodule

// File: tb/circ_index_step_tb.sv
`timescale 1ns/1ps
module circ_index_step_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] ctrl_word = '0;
  logic [31:0] limit_word = '0;
  logic        out_valid;
  logic [31:0] out_word;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic        m_valid;
  logic [31:0] m_word;

  always #2.5 clk = ~clk;

  circ_index_step u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ctrl_word(ctrl_word),
    .limit_word(limit_word), .out_valid(out_valid), .out_word(out_word)
  );

  function automatic logic [31:0] ref_next(input logic [31:0] c, input logic [31:0] l);
    int idx, stp, mx, s, r;
    idx = int'(c[15:0]);
    stp = int'($signed(c[31:16]));
    mx  = int'(l[15:0]);
    s   = idx + stp;
    if (stp > 0 && s > mx)      r = 0;
    else if (stp < 0 && s < 0)  r = mx;
    else                        r = s & 32'hFFFF;
    return {c[31:16], r[15:0]};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_word  <= '0;
    end else begin
      m_valid <= in_valid;
      if (in_valid) m_word <= ref_next(ctrl_word, limit_word);
    end
  end

  // R8 R2 per-cycle comparison with the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      checks++;
      if (out_valid !== m_valid || out_word !== m_word) begin
        fails++;
        $display("FAIL R8/R2 model: actual v=%0b w=%h expected v=%0b w=%h",
                 out_valid, out_word, m_valid, m_word);
      end
    end
  end

  task automatic check_word(input string tag, input logic [31:0] exp);
    checks++;
    if (out_valid !== 1'b1 || out_word !== exp) begin
      fails++;
      $display("FAIL %s: actual v=%0b w=%h expected v=1 w=%h", tag, out_valid, out_word, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [15:0] idx, input logic [15:0] stp,
                       input logic [31:0] lim, input logic [15:0] exp_idx);
    @(negedge clk);
    in_valid = 1'b1; ctrl_word = {stp, idx}; limit_word = lim;
    @(negedge clk);
    in_valid = 1'b0;
    check_word(tag, {stp, exp_idx});
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_word !== 32'h0) begin
      fails++;
      $display("FAIL R1 in reset: actual v=%0b w=%h expected v=0 w=0", out_valid, out_word);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_word !== 32'h0) begin
      fails++;
      $display("FAIL R1 after reset: actual v=%0b w=%h expected v=0 w=0", out_valid, out_word);
    end

    apply("R3 up",           16'd10,    16'd3,      32'd100,     16'd13);
    apply("R3 down",         16'd50,    16'hFFF9,   32'd100,     16'd43);
    apply("R9 at max",       16'd97,    16'd3,      32'd100,     16'd100);
    apply("R9 at zero",      16'd5,     16'hFFFB,   32'd100,     16'd0);
    apply("R4 past max",     16'd98,    16'd3,      32'd100,     16'd0);
    apply("R4 carry out",    16'hFFF0,  16'h7FFF,   32'h0000FFFF, 16'd0);
    apply("R5 below zero",   16'd2,     16'hFFFD,   32'd100,     16'd100);
    apply("R5 most negative",16'd0,     16'h8000,   32'h00001234, 16'h1234);
    apply("R6 zero step",    16'd500,   16'd0,      32'd100,     16'd500);
    apply("R7 upper limit",  16'd98,    16'd3,      32'hABCD0064, 16'd0);
    apply("R7 upper limit2", 16'd2,     16'hFFFD,   32'hFFFF0064, 16'd100);

    // R8: idle input with changed data must not disturb output
    held = out_word;
    @(negedge clk);
    ctrl_word = 32'h0001_0003; limit_word = 32'd9;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_word !== held) begin
      fails++;
      $display("FAIL R8 hold: actual v=%0b w=%h expected v=0 w=%h", out_valid, out_word, held);
    end

    // R8: back-to-back updates
    @(negedge clk);
    in_valid = 1'b1; ctrl_word = {16'd4, 16'd8}; limit_word = 32'd9;
    @(negedge clk);
    check_word("R8 back1", {16'd4, 16'd0});
    ctrl_word = {16'd4, 16'd0};
    @(negedge clk);
    in_valid = 1'b0;
    check_word("R8 back2", {16'd4, 16'd4});

    // random stream, judged by the per-cycle model
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      in_valid   = ($urandom_range(0, 3) != 0);
      ctrl_word  = $urandom;
      limit_word = $urandom;
      if (i % 5 == 0) limit_word[15:0] = 16'hFFFF;
      if (i % 7 == 0) ctrl_word[31:16] = 16'd0;
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule